// File: doc/BRIEF.md
# Indexed Codec Control Register Interface

This block is the host-facing control window of an audio codec. A host reaches it through four byte-wide direct ports chosen by a two-bit address: an index pointer, a data window into a bank of indirect control registers selected by that pointer, a status byte carrying the interrupt flag, and a programmed-I/O data port that this block does not implement. The bank has 32 byte registers. In legacy mode only the lower 16 can be reached; setting an extended-mode bit in register 12 widens the pointer by one bit.

The block applies the reset values, protects the read-only and reserved entries, and gates writes to the sample-format register behind mode-change-enable bits. It provides a short-lived autocalibration-busy indication that is armed when mode-change-enable rises. It also keeps the level interrupt: a pulse from the neighbouring DMA count block raises it, and the host acknowledges it. The format byte, the playback-enable bit, the interrupt-enable bit and the 16-bit base count are driven out to neighbouring logic.

Top module: `codec_regif`

## Requirements
- R1: Port address 0 is the index pointer, 1 the data window, 2 status, 3 programmed-I/O data. Writes to port 3 are ignored and it reads 0. After reset the bank holds 0x88 in entries 2, 3, 4, 5, 18 and 19, 0x80 in 6 and 7, 0x08 in 9, 0x8A in 12, 0xA0 in 25 and 26, and 0 elsewhere. Status reads 0 after reset.
- R2: A write to port 0 stores bits 6:0 and clears bit 7. Port 0 reads the stored value with bit 7 equal to 0. Its reset value is 0x40, and bit 6 is the mode-change-enable (MCE) flag.
- R3: When entry 12 bit 6 is 0, the data window uses pointer bits 3:0. For example, pointer 0x58 then reaches entry 8. When entry 12 bit 6 is 1, the data window uses bits 4:0. A write to entry 12 changes only its bit 6.
- R4: Writes to entries 11, 22, 27 and 29 have no effect.
- R5: A write to entry 8 is taken whole when MCE is 1. When MCE is 0 and entry 24 bit 4 is 1, only bits 7:4 are taken and bits 3:0 keep their old value. Otherwise the write is dropped.
- R6: A write to entry 9 always stores bit 5 as 0.
- R7: A port-0 write that takes MCE from 0 to 1 while entry 9 bit 3 or bit 4 is 1 arms a calibration counter with 1. Each data-window read of entry 11 while the counter is nonzero returns bit 5 set and decrements the counter. Otherwise entry 11 reads its stored value.
- R8: A one-cycle pulse on dma_irq_set sets status bit 0, irq_out and entry 24 bit 4 from the next cycle. If the pulse arrives in the same cycle as a clearing write, the set wins.
- R9: Any write to port 2 clears status bit 0, irq_out and entry 24 bits 6:4.
- R10: A write to entry 24 with bit 4 at 0, while bit 4 was 1, clears status bit 0 and irq_out. A write with bit 4 at 1 leaves the interrupt unchanged.
- R11: The outputs follow the bank: fmt_out is entry 8, play_en is entry 9 bit 0, irq_en is entry 10 bit 1, and base_count is {entry 14, entry 15}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe (never together with bus_wr) |
| bus_addr | input | 2 | Direct port select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed port, valid in the strobe cycle |
| dma_irq_set | input | 1 | Playback interrupt request pulse |
| irq_out | output | 1 | Level interrupt line |
| fmt_out | output | 8 | Sample format byte |
| play_en | output | 1 | Playback enable |
| irq_en | output | 1 | Interrupt enable |
| base_count | output | 16 | Playback base count, upper byte first |

## Verification
The bench sweeps every bank entry in both pointer widths. It then drives the same pointer values in legacy and extended mode, which separates a correct pointer mask from one that is always wide or always narrow. Format writes are tried in each of the three gate states, with distinct low and high nibbles, so a whole accept, a nibble merge and a drop each give a different value. The interrupt is raised and then cleared by the status port, by a falling bit 4 of entry 24, and by a clear that arrives in the same cycle as a set, which checks the priority. A long random run of mixed reads, writes and interrupt pulses then exercises the interaction of calibration arming, mode switching and acknowledge.

// File: rtl/codec_regif_pkg.sv
package codec_regif_pkg;
  localparam int DW       = 8;
  localparam int NREG     = 32;
  localparam int SEL_W    = $clog2(NREG);
  localparam int LEGACY_W = SEL_W - 1;
  localparam int PTR_W    = 7;

  localparam int I_FMT  = 8;
  localparam int I_IFC  = 9;
  localparam int I_PIN  = 10;
  localparam int I_ERR  = 11;
  localparam int I_MODE = 12;
  localparam int I_CNTH = 14;
  localparam int I_CNTL = 15;
  localparam int I_RSV0 = 22;
  localparam int I_AFS  = 24;
  localparam int I_RSV1 = 27;
  localparam int I_RSV2 = 29;

  localparam int B_MCE     = 6;
  localparam int B_EXT     = 6;
  localparam int B_CALFLAG = 5;
  localparam int B_IFC_RSV = 5;
  localparam int B_CAL_A   = 3;
  localparam int B_CAL_B   = 4;
  localparam int B_PI      = 4;
  localparam int B_TI      = 6;
  localparam int B_PEN     = 0;
  localparam int B_IEN     = 1;

  typedef enum logic [1:0] {
    P_INDEX  = 2'd0,
    P_DATA   = 2'd1,
    P_STATUS = 2'd2,
    P_PIO    = 2'd3
  } port_e;

  typedef logic [DW-1:0] byte_t;

  function automatic byte_t reset_value(int unsigned i);
    case (i)
      2, 3, 4, 5, 18, 19: return 8'h88;
      6, 7:               return 8'h80;
      9:                  return 8'h08;
      12:                 return 8'h8A;
      25, 26:             return 8'hA0;
      default:            return 8'h00;
    endcase
  endfunction

  function automatic logic is_locked(logic [SEL_W-1:0] s);
    return (int'(s) == I_ERR) || (int'(s) == I_RSV0) ||
           (int'(s) == I_RSV1) || (int'(s) == I_RSV2);
  endfunction

  function automatic logic [SEL_W-1:0] select(logic [PTR_W-1:0] ptr, logic ext);
    return ext ? ptr[SEL_W-1:0] : {1'b0, ptr[LEGACY_W-1:0]};
  endfunction

  function automatic byte_t fmt_merge(byte_t old, byte_t nw, logic whole);
    return whole ? nw : {nw[DW-1:DW/2], old[DW/2-1:0]};
  endfunction
endpackage

// File: rtl/codec_index_port.sv
module codec_index_port
  import codec_regif_pkg::*;
#(
  parameter int CAL_W    = 2,
  parameter int CAL_LOAD = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_we,
  input  byte_t            wdata,
  input  logic             cal_arm_ok,
  input  logic             err_rd,
  output logic [PTR_W-1:0] ptr_q,
  output logic             mce,
  output logic             cal_busy,
  output logic             mce_rise
);
  logic [CAL_W-1:0] cal_cnt;
  logic             cal_load;
  logic             cal_dec;

  assign mce      = ptr_q[B_MCE];
  assign mce_rise = idx_we && !mce && wdata[B_MCE];
  assign cal_load = mce_rise && cal_arm_ok;
  assign cal_busy = (cal_cnt != '0);
  assign cal_dec  = err_rd && cal_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= PTR_W'(8'h40);
      cal_cnt <= '0;
    end else begin
      if (idx_we) ptr_q <= wdata[PTR_W-1:0];
      if (cal_load)     cal_cnt <= CAL_W'(CAL_LOAD);
      else if (cal_dec) cal_cnt <= cal_cnt - 1'b1;
    end
  end

  p_cal_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_load |=> cal_busy);
  p_cal_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_dec && cal_cnt == CAL_W'(1) && !cal_load) |=> !cal_busy);
  p_cal_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_load && !err_rd) |=> $stable(cal_cnt));
  p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_we |=> $stable(ptr_q));
endmodule

// File: rtl/codec_reg_bank.sv
module codec_reg_bank
  import codec_regif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_we,
  input  logic [SEL_W-1:0] sel,
  input  byte_t            wdata,
  input  logic             mce,
  input  logic             stat_we,
  input  logic             irq_set,
  output byte_t            regs_q [NREG],
  output logic             pi_drop
);
  byte_t nxt [NREG];
  logic  fmt_ok;
  logic  fmt_hit;

  assign fmt_ok  = mce || regs_q[I_AFS][B_PI];
  assign fmt_hit = data_we && (int'(sel) == I_FMT);
  assign pi_drop = data_we && (int'(sel) == I_AFS) &&
                   regs_q[I_AFS][B_PI] && !wdata[B_PI];

  always_comb begin
    for (int i = 0; i < NREG; i++) nxt[i] = regs_q[i];
    if (data_we && !is_locked(sel)) begin
      case (int'(sel))
        I_FMT:  if (fmt_ok) nxt[I_FMT] = fmt_merge(regs_q[I_FMT], wdata, mce);
        I_IFC:  nxt[I_IFC] = wdata & ~(byte_t'(1) << B_IFC_RSV);
        I_MODE: nxt[I_MODE][B_EXT] = wdata[B_EXT];
        default: nxt[sel] = wdata;
      endcase
    end
    if (stat_we) nxt[I_AFS][B_TI:B_PI] = '0;
    if (irq_set) nxt[I_AFS][B_PI] = 1'b1;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) regs_q[g] <= reset_value(g);
      else        regs_q[g] <= nxt[g];
    end
  end

  p_err_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && int'(sel) == I_ERR) |=> $stable(regs_q[I_ERR]));
  p_rsv_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && int'(sel) == I_RSV0) |=> $stable(regs_q[I_RSV0]));
  p_fmt_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_hit && !mce && !regs_q[I_AFS][B_PI]) |=> $stable(regs_q[I_FMT]));
  p_fmt_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_hit && !mce) |=> (regs_q[I_FMT][3:0] == $past(regs_q[I_FMT][3:0])));
  p_ifc_rsv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && int'(sel) == I_IFC) |=> !regs_q[I_IFC][B_IFC_RSV]);
  p_pi_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> regs_q[I_AFS][B_PI]);
  p_ack_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && !irq_set) |=> (regs_q[I_AFS][B_TI:B_PI] == 3'b000));
endmodule

// File: rtl/codec_irq_ctrl.sv
module codec_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_set,
  input  logic stat_we,
  input  logic pi_drop,
  output logic int_q
);
  logic ack;
  assign ack = stat_we || pi_drop;

  always_ff @(posedge clk) begin
    if (!rst_n)       int_q <= 1'b0;
    else if (irq_set) int_q <= 1'b1;
    else if (ack)     int_q <= 1'b0;
  end

  p_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> int_q);
  p_stat_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && !irq_set) |=> !int_q);
  p_pi_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pi_drop && !irq_set) |=> !int_q);
  p_int_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_set && !ack) |=> $stable(int_q));
endmodule

// File: rtl/codec_regif.sv
module codec_regif
  import codec_regif_pkg::*;
#(
  parameter int CAL_W    = 2,
  parameter int CAL_LOAD = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        dma_irq_set,
  output logic        irq_out,
  output logic [7:0]  fmt_out,
  output logic        play_en,
  output logic        irq_en,
  output logic [15:0] base_count
);
  port_e            port;
  logic             idx_we, data_we, data_rd, stat_we;
  logic [PTR_W-1:0] ptr_q;
  logic             mce, cal_busy, mce_rise;
  logic             ext_mode;
  logic [SEL_W-1:0] sel;
  logic             err_rd;
  logic             cal_arm_ok;
  logic             pi_drop;
  logic             int_q;
  byte_t            regs_q [NREG];

  assign port     = port_e'(bus_addr);
  assign idx_we   = bus_wr && (port == P_INDEX);
  assign data_we  = bus_wr && (port == P_DATA);
  assign data_rd  = bus_rd && (port == P_DATA);
  assign stat_we  = bus_wr && (port == P_STATUS);

  assign ext_mode   = regs_q[I_MODE][B_EXT];
  assign sel        = select(ptr_q, ext_mode);
  assign err_rd     = data_rd && (int'(sel) == I_ERR);
  assign cal_arm_ok = regs_q[I_IFC][B_CAL_A] || regs_q[I_IFC][B_CAL_B];

  codec_index_port #(.CAL_W(CAL_W), .CAL_LOAD(CAL_LOAD)) u_index (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_we     (idx_we),
    .wdata      (bus_wdata),
    .cal_arm_ok (cal_arm_ok),
    .err_rd     (err_rd),
    .ptr_q      (ptr_q),
    .mce        (mce),
    .cal_busy   (cal_busy),
    .mce_rise   (mce_rise)
  );

  codec_reg_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_we (data_we),
    .sel     (sel),
    .wdata   (bus_wdata),
    .mce     (mce),
    .stat_we (stat_we),
    .irq_set (dma_irq_set),
    .regs_q  (regs_q),
    .pi_drop (pi_drop)
  );

  codec_irq_ctrl u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_set (dma_irq_set),
    .stat_we (stat_we),
    .pi_drop (pi_drop),
    .int_q   (int_q)
  );

  always_comb begin
    case (port)
      P_INDEX:  bus_rdata = {1'b0, ptr_q};
      P_DATA: begin
        bus_rdata = regs_q[sel];
        if (int'(sel) == I_ERR && cal_busy) bus_rdata[B_CALFLAG] = 1'b1;
      end
      P_STATUS: bus_rdata = {7'b0, int_q};
      default:  bus_rdata = 8'h00;
    endcase
  end

  assign irq_out    = int_q;
  assign fmt_out    = regs_q[I_FMT];
  assign play_en    = regs_q[I_IFC][B_PEN];
  assign irq_en     = regs_q[I_PIN][B_IEN];
  assign base_count = {regs_q[I_CNTH], regs_q[I_CNTL]};

  p_excl_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));
  p_rise_arms_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mce_rise && cal_arm_ok) |=> cal_busy);
  p_irq_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_irq_set |=> irq_out);
endmodule

// File: tb/codec_regif_test.sv
module codec_regif_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        dma_irq_set = 1'b0;
  logic        irq_out;
  logic [7:0]  fmt_out;
  logic        play_en;
  logic        irq_en;
  logic [15:0] base_count;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  int m_reg [32];
  int m_ptr;
  int m_cal;
  int m_int;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_regif uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_irq_set(dma_irq_set), .irq_out(irq_out), .fmt_out(fmt_out),
    .play_en(play_en), .irq_en(irq_en), .base_count(base_count)
  );

  function automatic int rv(int i);
    if (i >= 2 && i <= 5) return 'h88;
    if (i == 18 || i == 19) return 'h88;
    if (i == 6 || i == 7) return 'h80;
    if (i == 9) return 'h08;
    if (i == 12) return 'h8A;
    if (i == 25 || i == 26) return 'hA0;
    return 0;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 32; i++) m_reg[i] = rv(i);
    m_ptr = 'h40; m_cal = 0; m_int = 0;
  endtask

  function automatic int m_sel();
    if ((m_reg[12] & 'h40) != 0) return m_ptr % 32;
    return m_ptr % 16;
  endfunction

  function automatic int m_read(int a);
    int v;
    if (a == 0) return m_ptr;
    if (a == 2) return m_int;
    if (a == 3) return 0;
    v = m_reg[m_sel()];
    if (m_sel() == 11 && m_cal > 0) v = v | 'h20;
    return v;
  endfunction

  task automatic m_step(bit wr, bit rd, int a, int d, bit setq);
    int s;
    s = m_sel();
    if (rd && a == 1 && s == 11 && m_cal > 0) m_cal = m_cal - 1;
    if (wr && a == 0) begin
      if ((m_ptr & 'h40) == 0 && (d & 'h40) != 0 && (m_reg[9] & 'h18) != 0) m_cal = 1;
      m_ptr = d & 'h7F;
    end
    if (wr && a == 1) begin
      if (s == 11 || s == 22 || s == 27 || s == 29) begin
      end else if (s == 8) begin
        if ((m_ptr & 'h40) != 0) m_reg[8] = d;
        else if ((m_reg[24] & 'h10) != 0) m_reg[8] = (d & 'hF0) | (m_reg[8] & 'h0F);
      end else if (s == 9) m_reg[9] = d & 'hDF;
      else if (s == 12) m_reg[12] = (m_reg[12] & 'hBF) | (d & 'h40);
      else if (s == 24) begin
        if ((m_reg[24] & 'h10) != 0 && (d & 'h10) == 0) m_int = 0;
        m_reg[24] = d;
      end else m_reg[s] = d;
    end
    if (wr && a == 2) begin
      m_int = 0;
      m_reg[24] = m_reg[24] & 'h8F;
    end
    if (setq) begin
      m_int = 1;
      m_reg[24] = m_reg[24] | 'h10;
    end
  endtask

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic cyc(bit wr, bit rd, int a, int d, bit setq, string req);
    @(negedge clk);
    check("R8 irq_out", int'(irq_out), m_int);
    check("R11 fmt_out", int'(fmt_out), m_reg[8]);
    check("R11 play_en", int'(play_en), m_reg[9] % 2);
    check("R11 irq_en", int'(irq_en), (m_reg[10] / 2) % 2);
    check("R11 base_count", int'(base_count), m_reg[14] * 256 + m_reg[15]);
    bus_wr = wr; bus_rd = rd; bus_addr = 2'(a); bus_wdata = 8'(d); dma_irq_set = setq;
    #1;
    if (rd) check(req, int'(bus_rdata), m_read(a));
    m_step(wr, rd, a, d, setq);
    @(posedge clk);
    #1;
    bus_wr = 0; bus_rd = 0; dma_irq_set = 0;
  endtask

  task automatic wr(int a, int d, string req); cyc(1, 0, a, d, 0, req); endtask
  task automatic rd(int a, string req); cyc(0, 1, a, 0, 0, req); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 R2 reset state
    rd(0, "R2 reset index");
    rd(2, "R1 reset status");
    rd(3, "R1 pio read");
    wr(3, 'hFF, "R1 pio write");
    rd(3, "R1 pio read after write");
    for (int i = 0; i < 16; i++) begin
      wr(0, 'h40 | i, "R2");
      rd(1, "R1 legacy reset value");
    end
    // R3 extended mode
    wr(0, 'h4C, "R3");
    wr(1, 'h40, "R3 enter ext");
    for (int i = 0; i < 32; i++) begin
      wr(0, 'h40 | i, "R2");
      rd(1, "R1 ext reset value");
    end
    // R4 locked entries
    foreach (m_reg[j]) begin
      if (j == 11 || j == 22 || j == 27 || j == 29) begin
        wr(0, 'h40 | j, "R4");
        wr(1, 'hFF, "R4");
        rd(1, "R4 locked entry");
      end
    end
    // R3 mode bit only, aliasing in legacy
    wr(0, 'h4C, "R3");
    wr(1, 'hFF, "R3");
    rd(1, "R3 mode only bit6");
    wr(1, 'h00, "R3 leave ext");
    rd(1, "R3 mode cleared");
    wr(0, 'h58, "R3");
    wr(1, 'h5A, "R3 alias write");
    rd(1, "R3 alias read");
    wr(0, 'h48, "R3");
    rd(1, "R3 alias target");
    wr(0, 'h4C, "R3");
    wr(1, 'h40, "R3 ext again");
    // R2 bit7, R6
    wr(0, 'hC9, "R2");
    rd(0, "R2 bit7 cleared");
    wr(1, 'hFF, "R6");
    rd(1, "R6 bit5 forced");
    wr(1, 'h18, "R6");
    // R7 calibration
    wr(0, 'h0B, "R7");
    wr(0, 'h4B, "R7 arm");
    rd(1, "R7 flag set");
    rd(1, "R7 flag drained");
    wr(0, 'h49, "R7");
    wr(1, 'h00, "R7 disarm ifc");
    wr(0, 'h0B, "R7");
    wr(0, 'h4B, "R7 no arm");
    rd(1, "R7 flag not armed");
    wr(0, 'h49, "R7");
    wr(1, 'h08, "R7");
    // R5 format gating
    wr(0, 'h08, "R5");
    wr(1, 'h33, "R5 dropped");
    rd(1, "R5 drop kept");
    wr(0, 'h18, "R5");
    wr(1, 'h10, "R5 pmce");
    wr(0, 'h08, "R5");
    wr(1, 'hC7, "R5 merge");
    rd(1, "R5 nibble merge");
    wr(0, 'h48, "R5");
    wr(1, 'h12, "R5 whole");
    rd(1, "R5 whole accept");
    // R8 R9 R10 interrupt
    wr(0, 'h58, "R8");
    wr(1, 'h00, "R8");
    cyc(0, 0, 0, 0, 1, "R8 set");
    rd(2, "R8 status set");
    rd(1, "R8 afs bit4");
    wr(2, 0, "R9 ack");
    rd(2, "R9 status clear");
    rd(1, "R9 afs bits clear");
    cyc(0, 0, 0, 0, 1, "R10 set");
    wr(1, 'h00, "R10 drop bit4");
    rd(2, "R10 status clear");
    cyc(0, 0, 0, 0, 1, "R8 set");
    cyc(1, 0, 2, 0, 1, "R8 set beats ack");
    rd(2, "R8 priority");
    wr(2, 0, "R9 ack");
    wr(1, 'h10, "R10 raise bit4 by write");
    rd(2, "R10 no int");
    wr(1, 'h00, "R10 drop no int");
    rd(2, "R10 still clear");
    // R11 exports
    wr(0, 'h4E, "R11"); wr(1, 'h12, "R11");
    wr(0, 'h4F, "R11"); wr(1, 'h34, "R11");
    wr(0, 'h4A, "R11"); wr(1, 'h02, "R11");
    wr(0, 'h49, "R11"); wr(1, 'h09, "R11");
    cyc(0, 0, 0, 0, 0, "R11");
    // random mix
    for (int k = 0; k < 1500; k++) begin
      int op, a, d;
      bit s;
      op = int'($urandom % 3);
      a = int'($urandom % 4);
      d = int'($urandom % 256);
      s = (($urandom % 8) == 0);
      cyc(op == 0, op == 1, a, d, s, "R1 random");
    end
    cyc(0, 0, 0, 0, 0, "R11");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule